// File: doc/BRIEF.md
# Run-time configurable SPI master

This block is a full-duplex synchronous serial master. A host gives it a transmit word and a one-cycle start request. The block then generates the serial clock. On every bit period it shifts one bit out on MOSI and captures one bit from MISO. When the frame ends it returns the received word together with a one-cycle done pulse. A busy flag stays high from the cycle after the start is accepted until the cycle of the done pulse.

The following settings are picked per transfer and latched when the start request is accepted:
- clock idle level (polarity)
- which edge of each bit period samples the data (phase)
- frame length, 8 or 16 bits
- bit order
- serial clock half-period, as a count of system clocks

Slave select is not part of the shift engine. The host drives it as a plain level, and the block passes it to the pin through one register, so software can frame several words under one select.

Top module: `spi_xfer_master`

## Requirements
- R1: While reset is active, busy_o, done_o and sck_o are 0, rx_word_o is zero and ss_n_o is 1.
- R2: When no transfer runs, sck_o settles to the level of cpol_i one cycle after cpol_i changes. During a frame it starts at the latched polarity and ends at the latched polarity.
- R3: A frame has exactly 2N sck_o transitions, with N=16 when wide_i=1 and N=8 when wide_i=0.
- R4: When cpha_i=0, the first data bit is on mosi_o before the first sck_o transition. MISO is sampled on odd transitions and MOSI changes on even transitions. When cpha_i=1, MISO is sampled on even transitions and MOSI changes on odd transitions after the first one.
- R5: Full duplex: each MISO bit is captured at its sampling transition, and the captured bits make up rx_word_o. A 16-bit frame sends all of tx_word_i. An 8-bit frame sends tx_word_i[7:0] and returns rx_word_o[15:8]=0.
- R6: lsb_first_i=0 sends and receives the most significant frame bit first. lsb_first_i=1 sends and receives bit 0 first.
- R7: A start accepted while idle raises busy_o on the next cycle. busy_o then stays high for exactly (2N+1)*(half_div_i+1) cycles: each sck_o half-period lasts half_div_i+1 clocks, and one extra half-period follows the last transition.
- R8: done_o is high for a single cycle, in the cycle busy_o falls. rx_word_o is valid in that cycle and holds until the next done.
- R9: start_i asserted during a frame is ignored, and changes to the configuration inputs or tx_word_i during a frame have no effect on that frame.
- R10: ss_n_o equals ss_n_i delayed by one clock, whether or not a transfer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| tx_word_i | input | LONG_W | Word to transmit |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | 0: sample on first edge of a bit, 1: on second edge |
| wide_i | input | 1 | 1: 16-bit frame, 0: 8-bit frame |
| lsb_first_i | input | 1 | 1: bit 0 first, 0: top bit first |
| half_div_i | input | DIV_W | Serial clock half-period minus one, in system clocks |
| ss_n_i | input | 1 | Slave select level requested by the host |
| miso_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| ss_n_o | output | 1 | Registered slave select, active low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rx_word_o | output | LONG_W | Last received word |

## Verification
The bench models a slave that follows the phase rule. It samples MOSI and drives MISO on opposite edges, and it compares both words in both directions for all sixteen combinations of polarity, phase, length and order. A phase mix-up would shift the captured word by one bit. An order mix-up would return the words mirrored. An 8-bit frame that used the wrong half of the register would show bits in rx_word_o[15:8]. Timing corner cases get their own checks:
- a divider setting of zero and a large one, where an off-by-one in the divider would change the busy length
- a start pulse and configuration changes in the middle of a frame, which a design that failed to lock its settings would obey and so restart or corrupt the frame
- the final clock level, which would be wrong after an odd number of transitions

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
   // Per-frame settings, latched when a start is accepted
   typedef struct packed {
      logic cpol;
      logic cpha;
      logic wide;
      logic lsb_first;
   } spi_mode_t;
endpackage

// File: rtl/spi_xfer_divider.sv
module spi_xfer_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   // One tick every limit+1 clocks while running
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clr || !run)        cnt_q <= '0;
      else if (cnt_q == limit)     cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && !clr && (cnt_q == limit);
endmodule

// File: rtl/spi_xfer_sequencer.sv
module spi_xfer_sequencer #(
   parameter int LONG_W  = 16,
   parameter int SHORT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic tick,
   input  logic live_cpol,
   input  logic cpol_q,
   input  logic cpha_q,
   input  logic wide_q,
   output logic busy,
   output logic sck,
   output logic sample_stb,
   output logic shift_stb,
   output logic finish
);
   localparam int EW = $clog2(2 * LONG_W + 1);
   localparam logic [EW-1:0] EDGES_LONG  = EW'(2 * LONG_W);
   localparam logic [EW-1:0] EDGES_SHORT = EW'(2 * SHORT_W);

   logic          busy_q, sck_q;
   logic [EW-1:0] ecnt_q;
   logic [EW-1:0] last_edge;
   logic          edge_now, odd_edge;

   assign last_edge = wide_q ? EDGES_LONG : EDGES_SHORT;
   assign edge_now  = busy_q && tick && (ecnt_q != last_edge);
   assign finish    = busy_q && tick && (ecnt_q == last_edge);
   assign odd_edge  = ~ecnt_q[0];   // the edge about to happen is 1st, 3rd, ...

   assign sample_stb = edge_now && (cpha_q ? !odd_edge : odd_edge);
   assign shift_stb  = edge_now && (cpha_q ? (odd_edge && (ecnt_q != '0)) : !odd_edge);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         ecnt_q <= '0;
      end else if (go) begin
         busy_q <= 1'b1;
         sck_q  <= live_cpol;
         ecnt_q <= '0;
      end else if (finish) begin
         busy_q <= 1'b0;
         sck_q  <= cpol_q;
      end else if (edge_now) begin
         sck_q  <= ~sck_q;
         ecnt_q <= ecnt_q + 1'b1;
      end else if (!busy_q) begin
         sck_q  <= live_cpol;
      end
   end

   assign busy = busy_q;
   assign sck  = sck_q;
endmodule

// File: rtl/spi_xfer_datapath.sv
module spi_xfer_datapath #(
   parameter int LONG_W  = 16,
   parameter int SHORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_lsb,
   input  logic              load_wide,
   input  logic [LONG_W-1:0] tx_word,
   input  logic              wide_q,
   input  logic              lsb_q,
   input  logic              sample_stb,
   input  logic              shift_stb,
   input  logic              finish,
   input  logic              miso,
   output logic              mosi,
   output logic [LONG_W-1:0] rx_word,
   output logic              done
);
   localparam int PAD_W = LONG_W - SHORT_W;

   logic [LONG_W-1:0]  tx_sr_q, rx_sr_q, rx_word_q;
   logic [LONG_W-1:0]  tx_rev_l, rx_rev_l, tx_in, rx_sel;
   logic [SHORT_W-1:0] tx_rev_s, rx_rev_s;
   logic               done_q;

   // Mirror the frame so the engine always shifts from the top bit
   for (genvar i = 0; i < LONG_W; i++) begin : g_rev_long
      assign tx_rev_l[i] = tx_word[LONG_W-1-i];
      assign rx_rev_l[i] = rx_sr_q[LONG_W-1-i];
   end
   for (genvar i = 0; i < SHORT_W; i++) begin : g_rev_short
      assign tx_rev_s[i] = tx_word[SHORT_W-1-i];
      assign rx_rev_s[i] = rx_sr_q[SHORT_W-1-i];
   end

   always_comb begin
      if (!load_lsb)     tx_in = tx_word;
      else if (load_wide) tx_in = tx_rev_l;
      else               tx_in = {{PAD_W{1'b0}}, tx_rev_s};
   end

   always_comb begin
      if (wide_q) rx_sel = lsb_q ? rx_rev_l : rx_sr_q;
      else        rx_sel = {{PAD_W{1'b0}}, (lsb_q ? rx_rev_s : rx_sr_q[SHORT_W-1:0])};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr_q   <= '0;
         rx_sr_q   <= '0;
         rx_word_q <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= finish;
         if (load) begin
            tx_sr_q <= tx_in;
            rx_sr_q <= '0;
         end else begin
            if (shift_stb)  tx_sr_q <= {tx_sr_q[LONG_W-2:0], 1'b0};
            if (sample_stb) rx_sr_q <= {rx_sr_q[LONG_W-2:0], miso};
         end
         if (finish) rx_word_q <= rx_sel;
      end
   end

   assign mosi    = wide_q ? tx_sr_q[LONG_W-1] : tx_sr_q[SHORT_W-1];
   assign rx_word = rx_word_q;
   assign done    = done_q;
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
   parameter int LONG_W  = 16,
   parameter int SHORT_W = 8,
   parameter int DIV_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LONG_W-1:0] tx_word_i,
   input  logic              cpol_i,
   input  logic              cpha_i,
   input  logic              wide_i,
   input  logic              lsb_first_i,
   input  logic [DIV_W-1:0]  half_div_i,
   input  logic              ss_n_i,
   input  logic              miso_i,
   output logic              sck_o,
   output logic              mosi_o,
   output logic              ss_n_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [LONG_W-1:0] rx_word_o
);
   import spi_xfer_pkg::*;

   if (SHORT_W < 2) begin : g_bad_short
      $error("SHORT_W must be at least 2");
   end
   if (LONG_W <= SHORT_W) begin : g_bad_long
      $error("LONG_W must exceed SHORT_W");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   spi_mode_t        mode_live, mode_q;
   logic [DIV_W-1:0] div_q;
   logic             go, tick, busy, sample_stb, shift_stb, finish, ss_q;

   assign mode_live = '{cpol: cpol_i, cpha: cpha_i, wide: wide_i, lsb_first: lsb_first_i};
   assign go        = start_i && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         div_q  <= '0;
         ss_q   <= 1'b1;
      end else begin
         ss_q <= ss_n_i;
         if (go) begin
            mode_q <= mode_live;
            div_q  <= half_div_i;
         end
      end
   end

   spi_xfer_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (go),
      .run   (busy),
      .limit (div_q),
      .tick  (tick)
   );

   spi_xfer_sequencer #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .tick       (tick),
      .live_cpol  (cpol_i),
      .cpol_q     (mode_q.cpol),
      .cpha_q     (mode_q.cpha),
      .wide_q     (mode_q.wide),
      .busy       (busy),
      .sck        (sck_o),
      .sample_stb (sample_stb),
      .shift_stb  (shift_stb),
      .finish     (finish)
   );

   spi_xfer_datapath #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (go),
      .load_lsb   (lsb_first_i),
      .load_wide  (wide_i),
      .tx_word    (tx_word_i),
      .wide_q     (mode_q.wide),
      .lsb_q      (mode_q.lsb_first),
      .sample_stb (sample_stb),
      .shift_stb  (shift_stb),
      .finish     (finish),
      .miso       (miso_i),
      .mosi       (mosi_o),
      .rx_word    (rx_word_o),
      .done       (done_o)
   );

   assign busy_o = busy;
   assign ss_n_o = ss_q;
endmodule

// File: rtl/spi_xfer_checker.sv
module spi_xfer_checker #(
   parameter int LONG_W  = 16,
   parameter int SHORT_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic busy_o,
   input logic done_o,
   input logic sck_o,
   input logic cpol_i,
   input logic ss_n_i,
   input logic ss_n_o,
   input logic wide_q
);
   localparam int CW = $clog2(2 * LONG_W + 1);

   logic          alive_q, sck_d, busy_d;
   logic [CW-1:0] ecount_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alive_q  <= 1'b0;
         sck_d    <= 1'b0;
         busy_d   <= 1'b0;
         ecount_q <= '0;
      end else begin
         alive_q <= 1'b1;
         sck_d   <= sck_o;
         busy_d  <= busy_o;
         if (busy_o && !busy_d)                 ecount_q <= '0;
         else if (busy_o && (sck_o != sck_d))   ecount_q <= ecount_q + 1'b1;
      end
   end

   // R3: transitions seen during the frame match the frame length
   p_edge_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ecount_q == (wide_q ? CW'(2 * LONG_W) : CW'(2 * SHORT_W)));

   // R2: a frame starts at the requested idle level
   p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (alive_q && $rose(busy_o)) |-> sck_o == $past(cpol_i));

   // R7: an idle start is always taken
   p_start_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R8: done lasts one cycle and marks the fall of busy
   p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R10: select follows the host one clock later
   p_ss_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      alive_q |-> ss_n_o == $past(ss_n_i));
endmodule

bind spi_xfer_master spi_xfer_checker #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .sck_o   (sck_o),
   .cpol_i  (cpol_i),
   .ss_n_i  (ss_n_i),
   .ss_n_o  (ss_n_o),
   .wide_q  (mode_q.wide)
);

// File: tb/tb_spi_xfer_master.sv
module tb_spi_xfer_master;
   localparam int CLK_PERIOD = 10;
   localparam int LW = 16;
   localparam int SW = 8;
   localparam int DW = 8;

   logic          clk, rst_n, start_i, cpol_i, cpha_i, wide_i, lsb_first_i, ss_n_i, miso_i;
   logic [LW-1:0] tx_word_i;
   logic [DW-1:0] half_div_i;
   logic          sck_o, mosi_o, ss_n_o, busy_o, done_o;
   logic [LW-1:0] rx_word_o;

   int errs = 0;
   int checks = 0;

   spi_xfer_master #(.LONG_W(LW), .SHORT_W(SW), .DIV_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_word_i(tx_word_i),
      .cpol_i(cpol_i), .cpha_i(cpha_i), .wide_i(wide_i), .lsb_first_i(lsb_first_i),
      .half_div_i(half_div_i), .ss_n_i(ss_n_i), .miso_i(miso_i),
      .sck_o(sck_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o), .busy_o(busy_o),
      .done_o(done_o), .rx_word_o(rx_word_o)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [LW-1:0] frame_mask(input bit wide);
      return wide ? 16'hFFFF : 16'h00FF;
   endfunction

   function automatic logic slave_bit(input logic [LW-1:0] w, input int i,
                                      input int n, input bit lsb);
      return lsb ? w[i] : w[n-1-i];
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      errs++;
      checks++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   // One frame against a bench slave model; caller is at a falling clock edge
   task automatic xfer(input logic [LW-1:0] tx, input logic [LW-1:0] sw,
                       input bit pol, input bit pha, input bit wide, input bit lsb,
                       input int div, input bit poke);
      int n, edges, idx, capt, busy_cnt, exp_busy;
      bit odd;
      logic prev;
      logic [LW-1:0] got, held;
      string rq;
      n = wide ? LW : SW;
      edges = 0; idx = 0; capt = 0; got = '0;
      rq = poke ? "R9" : "R5";
      tx_word_i = tx; cpol_i = pol; cpha_i = pha; wide_i = wide;
      lsb_first_i = lsb; half_div_i = DW'(div);
      miso_i = slave_bit(sw, 0, n, lsb);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R7", "busy after start", int'(busy_o), 1);
      chk(sck_o == pol, "R2", "sck before first edge", int'(sck_o), int'(pol));
      prev = sck_o;
      busy_cnt = 1;
      while (busy_o && busy_cnt < 20000) begin
         if (poke && busy_cnt == 3) begin
            start_i = 1'b1; tx_word_i = ~tx; cpol_i = ~pol; cpha_i = ~pha;
            wide_i = ~wide; lsb_first_i = ~lsb; half_div_i = DW'(div + 1);
         end else if (poke && busy_cnt == 4) begin
            start_i = 1'b0; tx_word_i = tx; cpol_i = pol; cpha_i = pha;
            wide_i = wide; lsb_first_i = lsb; half_div_i = DW'(div);
         end
         @(negedge clk);
         if (busy_o && sck_o != prev) begin
            edges++;
            odd = (edges % 2) == 1;
            if (pha ? !odd : odd) begin
               if (capt < n) begin
                  if (lsb) got[capt] = mosi_o;
                  else     got[n-1-capt] = mosi_o;
               end
               capt++;
            end else if (!(pha && edges == 1)) begin
               idx++;
               if (idx < n) miso_i = slave_bit(sw, idx, n, lsb);
            end
         end
         prev = sck_o;
         if (busy_o) busy_cnt++;
      end
      exp_busy = (2 * n + 1) * (div + 1);
      chk(busy_cnt == exp_busy, poke ? "R9" : "R7", "busy length", busy_cnt, exp_busy);
      chk(edges == 2 * n, "R3", "sck transitions", edges, 2 * n);
      chk(sck_o == pol, "R2", "sck after frame", int'(sck_o), int'(pol));
      chk(done_o == 1'b1, "R8", "done at busy fall", int'(done_o), 1);
      chk(rx_word_o == (sw & frame_mask(wide)), lsb ? "R6" : rq, "received word",
          int'(rx_word_o), int'(sw & frame_mask(wide)));
      chk(got == (tx & frame_mask(wide)), pha ? "R4" : rq, "word seen by slave",
          int'(got), int'(tx & frame_mask(wide)));
      held = rx_word_o;
      @(negedge clk);
      chk(done_o == 1'b0, "R8", "done single cycle", int'(done_o), 0);
      chk(rx_word_o == held, "R8", "rx word held", int'(rx_word_o), int'(held));
   endtask

   initial begin
      int unsigned rnd;
      rst_n = 1'b0; start_i = 1'b0; tx_word_i = '0; cpol_i = 1'b0; cpha_i = 1'b0;
      wide_i = 1'b0; lsb_first_i = 1'b0; half_div_i = '0; ss_n_i = 1'b1; miso_i = 1'b0;
      rnd = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
      chk(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
      chk(sck_o == 1'b0, "R1", "sck in reset", int'(sck_o), 0);
      chk(rx_word_o == '0, "R1", "rx in reset", int'(rx_word_o), 0);
      chk(ss_n_o == 1'b1, "R1", "ss in reset", int'(ss_n_o), 1);
      rst_n = 1'b1;
      @(negedge clk);
      cpol_i = 1'b1;
      @(negedge clk);
      chk(sck_o == 1'b1, "R2", "idle sck follows polarity", int'(sck_o), 1);
      cpol_i = 1'b0;
      ss_n_i = 1'b0;
      @(negedge clk);
      chk(ss_n_o == 1'b0, "R10", "select low", int'(ss_n_o), 0);
      chk(sck_o == 1'b0, "R2", "idle sck low", int'(sck_o), 0);

      // Directed: every polarity / phase / length / order combination
      for (int m = 0; m < 16; m++) begin
         xfer(16'hA5C3 ^ LW'(m * 16'h1111), 16'h3C96 ^ LW'(m * 16'h0707),
              m[0], m[1], m[2], m[3], m % 3, 1'b0);
      end
      // Corner: all ones out, all zeros in, and the reverse
      xfer(16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0);
      xfer(16'h0000, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0);
      // Corner: long half-period
      xfer(16'h8001, 16'h1234, 1'b1, 1'b0, 1'b1, 1'b0, 200, 1'b0);
      // R9: start and setting changes during a frame
      xfer(16'h5A3C, 16'hC35A, 1'b0, 1'b1, 1'b1, 1'b0, 1, 1'b1);
      xfer(16'h00E7, 16'h0081, 1'b1, 1'b0, 1'b0, 1'b1, 2, 1'b1);

      // Random frames
      for (int k = 0; k < 24; k++) begin
         logic [LW-1:0] t, s;
         int cfg;
         t = LW'($urandom);
         s = LW'($urandom);
         cfg = int'($urandom % 16);
         xfer(t, s, cfg[0], cfg[1], cfg[2], cfg[3], int'($urandom % 4), (k % 6) == 5);
      end

      ss_n_i = 1'b1;
      @(negedge clk);
      chk(ss_n_o == 1'b1, "R10", "select high", int'(ss_n_o), 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule